// File: doc/BRIEF.md
# Period-Buffered 10-bit Pulse-Width Generator

This block drives one pulse-width-modulated output whose high time is resolved to a quarter of a timer tick. Its time base is an 8-bit tick counter with a 2-bit sub-tick counter below it. Together they form a 10-bit count that advances once per clock. An 8-bit period value sets the last tick of each period. When the tick counter reaches that value and the sub-tick counter is at its last step, the count returns to zero and a new period begins.

The 10-bit duty value is assembled from an 8-bit upper duty input and two low bits held in the control input. Software may change it at any time. The block copies it into an internal shadow register only at a period start, so a pulse that has already begun is never cut short or lengthened by a write. The output latch goes high at a period start when the shadowed duty is non-zero. It goes low when the 10-bit count reaches the shadowed duty. A one-clock period-start pulse is provided for neighbouring logic, and the pin follows the latch only while its output enable is high.

Top module: `pwm10_gen`

## Requirements
- R1: Right after reset, and while reset is held, `pwm_pin_o` and `period_match_o` are 0. The count starts at zero, so the first period-start pulse comes exactly 4*(P+1) clocks after reset is released, where P is `period_i`.
- R2: `period_match_o` is high for exactly one clock at the start of each period, and consecutive pulses are 4*(P+1) clocks apart.
- R3: The duty value D is `{duty_hi_i, ctrl_i[5:4]}`, with `ctrl_i[5:4]` as its two least significant bits. When 0 < D < 4*(P+1), the latch is high for exactly D clocks, starting in the same clock as the period-start pulse.
- R4: When the shadowed D is 0, the output stays low for the whole period. This holds even though the duty-reached event and the period restart fall in the same clock, including a period that directly follows one with a non-zero duty.
- R5: When D >= 4*(P+1), the output stays high for the whole period.
- R6: A change of `duty_hi_i` or `ctrl_i[5:4]` during a period does not alter that period's pulse. The new value governs the next period.
- R7: When `ctrl_i[3:2]` is not 2'b11, which includes a control value of 0, the latch is forced low at the next clock. After the mode returns to 2'b11, the latch stays low until the next period start.
- R8: While `oe_i` is 0, `pwm_pin_o` is 0. The latch keeps running, so the pin shows the latch again in the first cycle after `oe_i` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | 8 | Last tick value of a period (P) |
| duty_hi_i | input | 8 | Upper eight bits of the duty value |
| ctrl_i | input | 8 | Control: [5:4] duty low bits, [3:2] mode (2'b11 = run) |
| oe_i | input | 1 | Pin output enable |
| pwm_pin_o | output | 1 | Gated pulse-width output |
| period_match_o | output | 1 | One-clock pulse at each period start |

## Verification
The period restart and the duty-reached clear can land on the same clock. With a zero duty, the count returns to 0 in the very cycle it would be compared with the shadowed value. The bench provokes this by running a non-zero duty, then a zero duty, then a small non-zero duty in consecutive periods. It judges the outcome by the high-cycle count and the first-cycle level of each period. A mode-off write placed inside a pulse, and a mid-period duty write, check that the forcing paths and the shadow copy do not disturb one another.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

    // control input layout; neighbours decode these positions
    localparam int unsigned CTRL_W      = 8;
    localparam int unsigned CTL_DLO_LSB = 4;
    localparam int unsigned CTL_MODE_LSB = 2;

    typedef enum logic [1:0] {
        MODE_OFF0 = 2'b00,
        MODE_OFF1 = 2'b01,
        MODE_OFF2 = 2'b10,
        MODE_RUN  = 2'b11
    } pwm_mode_e;

endpackage

// File: rtl/pwm10_timebase.sv
module pwm10_timebase #(
    parameter int unsigned TMR_W = 8,
    parameter int unsigned SUB_W = 2,
    localparam int unsigned BASE_W = TMR_W + SUB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_W-1:0]  period_i,
    output logic [BASE_W-1:0] base_q_o,
    output logic [BASE_W-1:0] base_d_o,
    output logic              wrap_o,
    output logic              match_o
);

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              match;
    } tb_state_t;

    tb_state_t s_d, s_q;
    logic      wrap;

    always_comb begin
        wrap = (s_q.base[BASE_W-1 -: TMR_W] == period_i) &&
               (s_q.base[SUB_W-1:0] == {SUB_W{1'b1}});
        s_d       = s_q;
        s_d.match = wrap;
        if (wrap) s_d.base = '0;
        else      s_d.base = s_q.base + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign base_q_o = s_q.base;
    assign base_d_o = s_d.base;
    assign wrap_o   = wrap;
    assign match_o  = s_q.match;

    AST_MATCH_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.match |=> !s_q.match); // R2

    AST_MATCH_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.match |-> (s_q.base == '0)); // R2

endmodule

// File: rtl/pwm10_duty.sv
module pwm10_duty #(
    parameter int unsigned BASE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              wrap_i,
    input  logic [BASE_W-1:0] base_q_i,
    input  logic [BASE_W-1:0] base_d_i,
    input  logic [BASE_W-1:0] master_i,
    output logic              pwm_o
);

    typedef struct packed {
        logic [BASE_W-1:0] slave;
        logic              pwm;
    } duty_state_t;

    duty_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wrap_i) s_d.slave = master_i;
        if (!run_i)
            s_d.pwm = 1'b0;
        else if (wrap_i)
            s_d.pwm = (master_i != '0);
        else if (base_d_i == s_q.slave)
            s_d.pwm = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pwm_o = s_q.pwm;

    AST_SLAVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(s_q.slave)); // R6

    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.pwm) |-> (base_q_i == '0)); // R3

    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.slave == '0) |-> !s_q.pwm); // R4

    AST_OFF_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !s_q.pwm); // R7

endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
    import pwm10_pkg::*;
#(
    parameter int unsigned TMR_W = 8,
    parameter int unsigned SUB_W = 2,
    localparam int unsigned BASE_W = TMR_W + SUB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_W-1:0]  period_i,
    input  logic [TMR_W-1:0]  duty_hi_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              oe_i,
    output logic              pwm_pin_o,
    output logic              period_match_o
);

    logic [BASE_W-1:0] base_q, base_d, master;
    logic              wrap, run, latch;
    pwm_mode_e         mode;

    always_comb begin
        mode   = pwm_mode_e'(ctrl_i[CTL_MODE_LSB +: 2]);
        run    = (mode == MODE_RUN);
        master = {duty_hi_i, ctrl_i[CTL_DLO_LSB +: SUB_W]};
    end

    pwm10_timebase #(
        .TMR_W (TMR_W),
        .SUB_W (SUB_W)
    ) i_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_i),
        .base_q_o (base_q),
        .base_d_o (base_d),
        .wrap_o   (wrap),
        .match_o  (period_match_o)
    );

    pwm10_duty #(
        .BASE_W (BASE_W)
    ) i_duty (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .wrap_i   (wrap),
        .base_q_i (base_q),
        .base_d_i (base_d),
        .master_i (master),
        .pwm_o    (latch)
    );

    assign pwm_pin_o = oe_i & latch;

    AST_PIN_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_pin_o) |-> (period_match_o || $rose(oe_i))); // R8

endmodule

// File: tb/test_pwm10_gen.sv
module test_pwm10_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] period = 8'd9;
    logic [7:0] duty_hi = 8'd0;
    logic [7:0] ctrl = 8'd0;
    logic       oe = 1'b1;
    logic       pin, match;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    pwm10_gen i_pwm10_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .period_i       (period),
        .duty_hi_i      (duty_hi),
        .ctrl_i         (ctrl),
        .oe_i           (oe),
        .pwm_pin_o      (pin),
        .period_match_o (match)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mode run = ctrl[3:2]=2'b11, duty low bits in ctrl[5:4]
    task automatic set_cfg(input logic [7:0] p, input logic [7:0] hi, input logic [1:0] lo);
        period  = p;
        duty_hi = hi;
        ctrl    = {2'b00, lo, 2'b11, 2'b00};
    endtask

    task automatic wait_match();
        do @(negedge clk); while (!match);
    endtask

    // called at a negedge where match is high; ends at the next one
    task automatic measure(input int chg_at, input logic [7:0] chg_hi,
                           output int len, output int high, output int first);
        len = 0; high = 0; first = int'(pin);
        do begin
            if (len == chg_at) duty_hi = chg_hi;
            high += int'(pin);
            len++;
            @(negedge clk);
        end while (!match);
    endtask

    task automatic t_reset();
        int n;
        repeat (3) @(negedge clk);
        check("R1 pin in reset", int'(pin), 0);
        check("R1 match in reset", int'(match), 0);
        rst_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!match);
        check("R1 first period start", n, 40);
    endtask

    task automatic t_basic();
        int len, high, first;
        set_cfg(8'd9, 8'd2, 2'd2);
        wait_match();
        measure(-1, 8'd0, len, high, first);
        check("R2 period length", len, 40);
        check("R3 high time D=10", high, 10);
        check("R3 high at start", first, 1);
        set_cfg(8'd9, 8'd2, 2'd3);
        wait_match();
        measure(-1, 8'd0, len, high, first);
        check("R3 low bits D=11", high, 11);
        set_cfg(8'd5, 8'd0, 2'd1);
        wait_match();
        measure(-1, 8'd0, len, high, first);
        check("R2 period length P=5", len, 24);
        check("R3 minimum D=1", high, 1);
    endtask

    task automatic t_full();
        int len, high, first;
        set_cfg(8'd3, 8'd4, 2'd0);
        wait_match();
        measure(-1, 8'd0, len, high, first);
        check("R5 D equals period", high, 16);
        set_cfg(8'd3, 8'd255, 2'd3);
        wait_match();
        measure(-1, 8'd0, len, high, first);
        check("R5 D far above period", high, 16);
        check("R2 period length P=3", len, 16);
    endtask

    task automatic t_coincide();
        int len, high, first;
        set_cfg(8'd9, 8'd1, 2'd1);
        wait_match();
        set_cfg(8'd9, 8'd0, 2'd0);
        measure(-1, 8'd0, len, high, first);
        check("R4 prior period D=5", high, 5);
        set_cfg(8'd9, 8'd0, 2'd3);
        measure(-1, 8'd0, len, high, first);
        check("R4 zero duty high time", high, 0);
        check("R4 zero duty start level", first, 0);
        measure(-1, 8'd0, len, high, first);
        check("R4 after zero D=3", high, 3);
        check("R4 after zero start level", first, 1);
    endtask

    task automatic t_midchange();
        int len, high, first;
        set_cfg(8'd9, 8'd2, 2'd0);
        wait_match();
        measure(3, 8'd6, len, high, first);
        check("R6 current period kept", high, 8);
        measure(-1, 8'd0, len, high, first);
        check("R6 next period new duty", high, 24);
    endtask

    task automatic t_disable();
        int len, high, first;
        set_cfg(8'd9, 8'd7, 2'd2);
        wait_match();
        repeat (3) @(negedge clk);
        check("R7 high before disable", int'(pin), 1);
        ctrl = 8'h00;
        @(negedge clk);
        check("R7 forced low by zero control", int'(pin), 0);
        ctrl = 8'h2C;
        high = 0;
        do begin high += int'(pin); @(negedge clk); end while (!match);
        check("R7 low until next start", high, 0);
        measure(-1, 8'd0, len, high, first);
        check("R7 resumes D=30", high, 30);
    endtask

    task automatic t_oe();
        int len, high, first;
        set_cfg(8'd9, 8'd7, 2'd2);
        oe = 1'b0;
        wait_match();
        measure(-1, 8'd0, len, high, first);
        check("R8 pin gated low", high, 0);
        repeat (5) @(negedge clk);
        oe = 1'b1;
        @(negedge clk);
        check("R8 latch shown after enable", int'(pin), 1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_full();
        t_coincide();
        t_midchange();
        t_disable();
        t_oe();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule